// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is an 18-bit first-in first-out buffer. It has a write port and a read port, and each port runs on its own clock. Storage depth is a parameter (2048 words by default, 4096 also intended). Five status flags describe the fill level. Each flag is low when asserted:

- full
- programmable almost-full
- half-full
- programmable almost-empty
- empty

Two thresholds and a small feature register are written through the data input. On any write-clock edge where the load strobe is low, the word goes to the next register in a fixed rotation instead of into the buffer.

A mode pin is sampled while reset is held. It decides whether the feature bits start cleared or set. Three feature bits are defined:

- Bit 0 qualifies writes with a second, active-high write enable.
- Bit 1 qualifies reads with a second, active-high read enable.
- Bit 2 drives an extra empty output that lags the main empty flag by one read clock. Two devices can use it when chained.

The output-enable input forces the data output to zero. It does not disturb the buffer.

Top module: `dcf_top`

## Requirements
- R1: While `rst` is high (synchronous, held for at least three cycles of each clock), both pointers return to location 0. The flags then read `full_n`=1, `almost_full_n`=1, `half_full_n`=1, `almost_empty_n`=0 and `empty_n`=0. `dout` reads zero with `oe_n` low until the first word is read.
- R2: After reset, the almost-empty threshold and the almost-full threshold are both 127.
- R3: A buffer write happens on a rising `wr_clk` edge when three conditions hold: `load_n` is high, the effective write enable is asserted and `full_n` is high. Each read with the effective read enable asserted shows on `dout` at the read edge. Words come out in the order they were written.
- R4: While `full_n` is low, write attempts store nothing and change no state.
- R5: While `empty_n` is low, read attempts leave `dout` and the read pointer unchanged.
- R6: A rising `wr_clk` edge with `load_n` low and the effective write enable asserted writes one register. Successive loads cycle through a fixed order: almost-empty threshold (`din[AW-1:0]`), then almost-full threshold (`din[AW-1:0]`), then feature register (`din[2:0]`), then back to the start. Reset restarts the cycle at the almost-empty threshold.
- R7: Each flag has its own rule, where count is the number of stored words:
  - `almost_empty_n` is low when count ≤ the almost-empty threshold.
  - `almost_full_n` is low when DEPTH − count ≤ the almost-full threshold.
  - `half_full_n` is low when count > DEPTH/2.
  - `full_n` is low when count = DEPTH.
  - `empty_n` is low when count = 0.
- R8: If `mode_n` is high during reset, all feature bits reset to 0. If it is low, all feature bits reset to 1. Each bit can be reloaded later.
- R9: Feature bit 0 set: the effective write enable is `!wr_en_n && wr_en2`; otherwise it is `!wr_en_n` and `wr_en2` is ignored. Feature bit 1 does the same on the read side with `rd_en_n` and `rd_en2`.
- R10: Feature bit 2 set: `empty_dly_n` equals `empty_n` delayed by one `rd_clk` cycle. Feature bit 2 clear: `empty_dly_n` is held high.
- R11: `oe_n` high forces `dout` to zero. `oe_n` has no effect on reads, writes or flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Active-high reset, held across edges of both clocks |
| mode_n | input | 1 | Sampled during reset; low presets all feature bits |
| load_n | input | 1 | Low turns a write edge into a register load |
| wr_en_n | input | 1 | Write enable, active low |
| wr_en2 | input | 1 | Second write enable, active high, used when feature bit 0 is set |
| rd_en_n | input | 1 | Read enable, active low |
| rd_en2 | input | 1 | Second read enable, active high, used when feature bit 1 is set |
| oe_n | input | 1 | Output enable, active low |
| din | input | 18 | Data word, threshold value or feature word |
| dout | output | 18 | Read data, zero while `oe_n` is high |
| full_n | output | 1 | Low when full |
| almost_full_n | output | 1 | Low when free space is at or below its threshold |
| half_full_n | output | 1 | Low when more than half full |
| almost_empty_n | output | 1 | Low when the count is at or below its threshold |
| empty_n | output | 1 | Low when empty |
| empty_dly_n | output | 1 | Empty flag delayed one read clock (feature bit 2), else high |

## Verification
Each fault shows at the ports on its own timescale:

- A stuck or mis-stepped write pointer first shows as a wrong word in the read-back order. When it lets a write through while full, the extra word shows up after the last expected word is read.
- A wrong threshold or a load that went to the wrong register moves `almost_empty_n` or `almost_full_n` to the wrong side of a fill level. This is visible a few read or write clocks after the filling stops, once the pointer crossing settles.
- Flags in the same domain as the pointer that moved are checked in the very next cycle.
- The delayed empty output is checked edge by edge against the main empty flag.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int FEAT_W    = 3;
  localparam int FEAT_WEN2 = 0;
  localparam int FEAT_REN2 = 1;
  localparam int FEAT_EDLY = 2;

  typedef enum logic [1:0] {
    SEL_AE  = 2'd0,
    SEL_AF  = 2'd1,
    SEL_FT  = 2'd2
  } load_sel_e;

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync2.sv
`timescale 1ns/1ps
module dcf_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= rst_val;
      q    <= rst_val;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)  q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int WIDTH   = 18,
  parameter int DEPTH   = 2048,
  parameter int DEF_OFF = 127,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FEAT_W-1:0] feat_preset,
  input  logic              load_n,
  input  logic              we_n,
  input  logic              we2,
  input  logic [WIDTH-1:0]  din,
  input  logic [PW-1:0]     rgray_s,
  output logic [PW-1:0]     wbin,
  output logic [PW-1:0]     wgray,
  output logic              mem_we,
  output logic [FEAT_W-1:0] feat,
  output logic [AW-1:0]     ae_off,
  output logic              full_n,
  output logic              af_n,
  output logic              hf_n
);
  logic [AW-1:0] af_off;
  load_sel_e     sel;
  logic          eff_we, wr_ok, ld_ok;
  logic [PW-1:0] wbin_nx, rbin_s, used_nx, free_nx;

  always_comb begin
    eff_we  = !we_n && (feat[FEAT_WEN2] ? we2 : 1'b1);
    wr_ok   = eff_we && load_n && full_n;
    ld_ok   = eff_we && !load_n;
    wbin_nx = wbin + PW'(wr_ok);
    rbin_s  = PW'(gray_to_bin(32'(rgray_s)));
    used_nx = wbin_nx - rbin_s;
    free_nx = PW'(DEPTH) - used_nx;
  end

  assign mem_we = wr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin   <= '0;
      wgray  <= '0;
      full_n <= 1'b1;
      af_n   <= 1'b1;
      hf_n   <= 1'b1;
      sel    <= SEL_AE;
      ae_off <= AW'(DEF_OFF);
      af_off <= AW'(DEF_OFF);
      feat   <= feat_preset;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wbin_nx ^ (wbin_nx >> 1);
      full_n <= (used_nx != PW'(DEPTH));
      af_n   <= !(free_nx <= {1'b0, af_off});
      hf_n   <= !(used_nx > PW'(DEPTH / 2));
      if (ld_ok) begin
        unique case (sel)
          SEL_AE:  begin ae_off <= din[AW-1:0];     sel <= SEL_AF; end
          SEL_AF:  begin af_off <= din[AW-1:0];     sel <= SEL_FT; end
          default: begin feat   <= din[FEAT_W-1:0]; sel <= SEL_AE; end
        endcase
      end
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          re_n,
  input  logic          re2,
  input  logic          ren2_en,
  input  logic          edly_en,
  input  logic [AW-1:0] ae_off_s,
  input  logic [PW-1:0] wgray_s,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic          mem_re,
  output logic          empty_n,
  output logic          ae_n,
  output logic          empty_dly_n
);
  logic          eff_re, rd_ok, edly_q;
  logic [PW-1:0] rbin_nx, wbin_s, used_nx;

  always_comb begin
    eff_re  = !re_n && (ren2_en ? re2 : 1'b1);
    rd_ok   = eff_re && empty_n;
    rbin_nx = rbin + PW'(rd_ok);
    wbin_s  = PW'(gray_to_bin(32'(wgray_s)));
    used_nx = wbin_s - rbin_nx;
  end

  assign mem_re      = rd_ok;
  assign empty_dly_n = edly_en ? edly_q : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_n <= 1'b0;
      ae_n    <= 1'b0;
      edly_q  <= 1'b0;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rbin_nx ^ (rbin_nx >> 1);
      empty_n <= (used_nx != '0);
      ae_n    <= !(used_nx <= {1'b0, ae_off_s});
      edly_q  <= empty_n;
    end
  end
endmodule

// File: rtl/dcf_top.sv
`timescale 1ns/1ps
module dcf_top
  import dcf_pkg::*;
#(
  parameter int WIDTH   = 18,
  parameter int DEPTH   = 2048,
  parameter int DEF_OFF = 127,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst,
  input  logic             mode_n,
  input  logic             load_n,
  input  logic             wr_en_n,
  input  logic             wr_en2,
  input  logic             rd_en_n,
  input  logic             rd_en2,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full_n,
  output logic             almost_full_n,
  output logic             half_full_n,
  output logic             almost_empty_n,
  output logic             empty_n,
  output logic             empty_dly_n
);
  logic [FEAT_W-1:0] feat_preset, feat_w, feat_r;
  logic [PW-1:0]     wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  logic [AW-1:0]     ae_off_w, ae_off_r;
  logic              mem_we, mem_re;
  logic [WIDTH-1:0]  q;

  assign feat_preset = mode_n ? '0 : '1;

  dcf_wr_side #(.WIDTH(WIDTH), .DEPTH(DEPTH), .DEF_OFF(DEF_OFF)) u_wr (
    .clk(wr_clk), .rst(rst), .feat_preset(feat_preset), .load_n(load_n),
    .we_n(wr_en_n), .we2(wr_en2), .din(din), .rgray_s(rgray_s),
    .wbin(wbin), .wgray(wgray), .mem_we(mem_we), .feat(feat_w),
    .ae_off(ae_off_w), .full_n(full_n), .af_n(almost_full_n), .hf_n(half_full_n)
  );

  dcf_sync2 #(.W(PW)) u_sync_rptr (
    .clk(wr_clk), .rst(rst), .rst_val('0), .d(rgray), .q(rgray_s)
  );
  dcf_sync2 #(.W(PW)) u_sync_wptr (
    .clk(rd_clk), .rst(rst), .rst_val('0), .d(wgray), .q(wgray_s)
  );
  dcf_sync2 #(.W(FEAT_W)) u_sync_feat (
    .clk(rd_clk), .rst(rst), .rst_val(feat_preset), .d(feat_w), .q(feat_r)
  );
  dcf_sync2 #(.W(AW)) u_sync_aeoff (
    .clk(rd_clk), .rst(rst), .rst_val(AW'(DEF_OFF)), .d(ae_off_w), .q(ae_off_r)
  );

  dcf_rd_side #(.DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst(rst), .re_n(rd_en_n), .re2(rd_en2),
    .ren2_en(feat_r[FEAT_REN2]), .edly_en(feat_r[FEAT_EDLY]),
    .ae_off_s(ae_off_r), .wgray_s(wgray_s), .rbin(rbin), .rgray(rgray),
    .mem_re(mem_re), .empty_n(empty_n), .ae_n(almost_empty_n),
    .empty_dly_n(empty_dly_n)
  );

  dcf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .wr_clk(wr_clk), .we(mem_we), .waddr(wbin[AW-1:0]), .wdata(din),
    .rd_clk(rd_clk), .rd_rst(rst), .re(mem_re), .raddr(rbin[AW-1:0]), .q(q)
  );

  assign dout = oe_n ? '0 : q;
endmodule

// File: rtl/dcf_chk.sv
`timescale 1ns/1ps
module dcf_chk #(
  parameter int PW = 12
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst,
  input logic          full_n,
  input logic          af_n,
  input logic          hf_n,
  input logic          empty_n,
  input logic          ae_n,
  input logic          empty_dly_n,
  input logic          edly_en,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin
);
  p_no_overflow_r4: assert property (@(posedge wr_clk) disable iff (rst)
    !full_n |=> wbin == $past(wbin));

  p_no_underflow_r5: assert property (@(posedge rd_clk) disable iff (rst)
    !empty_n |=> rbin == $past(rbin));

  p_full_levels_r7: assert property (@(posedge wr_clk) disable iff (rst)
    !full_n |-> (!af_n && !hf_n));

  p_empty_levels_r7: assert property (@(posedge rd_clk) disable iff (rst)
    !empty_n |-> !ae_n);

  p_empty_delay_r10: assert property (@(posedge rd_clk) disable iff (rst)
    edly_en |-> empty_dly_n == $past(empty_n));
endmodule

bind dcf_top dcf_chk #(.PW(PW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .full_n(full_n),
  .af_n(almost_full_n), .hf_n(half_full_n), .empty_n(empty_n),
  .ae_n(almost_empty_n), .empty_dly_n(empty_dly_n),
  .edly_en(feat_r[dcf_pkg::FEAT_EDLY]), .wbin(wbin), .rbin(rbin)
);

// File: tb/dcf_top_test.sv
`timescale 1ns/1ps
module dcf_top_test;
  localparam int DEPTH = 2048;

  logic wr_clk = 0, rd_clk = 0, rst = 1, mode_n = 1, load_n = 1;
  logic wr_en_n = 1, wr_en2 = 0, rd_en_n = 1, rd_en2 = 0, oe_n = 0;
  logic [17:0] din = '0, dout;
  logic full_n, almost_full_n, half_full_n, almost_empty_n, empty_n, empty_dly_n;
  int checks = 0, errors = 0;

  dcf_top #(.DEPTH(DEPTH)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .mode_n(mode_n),
    .load_n(load_n), .wr_en_n(wr_en_n), .wr_en2(wr_en2), .rd_en_n(rd_en_n),
    .rd_en2(rd_en2), .oe_n(oe_n), .din(din), .dout(dout), .full_n(full_n),
    .almost_full_n(almost_full_n), .half_full_n(half_full_n),
    .almost_empty_n(almost_empty_n), .empty_n(empty_n), .empty_dly_n(empty_dly_n)
  );

  always #5 wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #5 rd_clk = ~rd_clk;
  end

  typedef struct packed {
    logic [10:0] ae; logic [10:0] af; logic [11:0] n;
    logic xae; logic xaf; logic xhf;
  } vec_t;
  localparam vec_t TBL [7] = '{
    '{11'd4,    11'd4,    12'd4,    1'b0, 1'b1, 1'b1},
    '{11'd4,    11'd4,    12'd5,    1'b1, 1'b1, 1'b1},
    '{11'd10,   11'd1000, 12'd1024, 1'b1, 1'b1, 1'b1},
    '{11'd10,   11'd1024, 12'd1025, 1'b1, 1'b0, 1'b0},
    '{11'd127,  11'd127,  12'd1921, 1'b1, 1'b0, 1'b0},
    '{11'd127,  11'd127,  12'd1920, 1'b1, 1'b1, 1'b0},
    '{11'd1500, 11'd5,    12'd1500, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    rst = 1; mode_n = m; load_n = 1; wr_en_n = 1; rd_en_n = 1;
    repeat (4) @(negedge wr_clk);
    rst = 0;
    @(negedge rd_clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic wr_burst(input int n, input logic [17:0] base);
    @(negedge wr_clk);
    for (int i = 0; i < n; i++) begin
      load_n = 1; wr_en_n = 0; din = base + 18'(i);
      @(negedge wr_clk);
    end
    wr_en_n = 1;
  endtask

  task automatic load_reg(input logic [17:0] v);
    @(negedge wr_clk);
    load_n = 0; wr_en_n = 0; din = v;
    @(negedge wr_clk);
    load_n = 1; wr_en_n = 1;
  endtask

  task automatic rd_word(output logic [17:0] d);
    @(negedge rd_clk);
    rd_en_n = 0;
    @(negedge rd_clk);
    rd_en_n = 1;
    d = dout;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] d;
    int mism;

    // R1 / R8 / R10: reset state in compatibility mode
    do_reset(1'b1);
    chk("R1 full_n", 32'(full_n), 1);
    chk("R1 almost_full_n", 32'(almost_full_n), 1);
    chk("R1 half_full_n", 32'(half_full_n), 1);
    chk("R1 almost_empty_n", 32'(almost_empty_n), 0);
    chk("R1 empty_n", 32'(empty_n), 0);
    chk("R1 dout zero", 32'(dout), 0);
    chk("R10 delayed empty held high, R8 bits clear", 32'(empty_dly_n), 1);

    // R6 / R7: threshold table
    foreach (TBL[k]) begin
      do_reset(1'b1);
      load_reg({7'd0, TBL[k].ae});
      load_reg({7'd0, TBL[k].af});
      load_reg(18'd0);
      wr_burst(int'(TBL[k].n), 18'h01000);
      settle();
      chk($sformatf("R7 vec%0d almost_empty_n", k), 32'(almost_empty_n), 32'(TBL[k].xae));
      chk($sformatf("R7 vec%0d almost_full_n", k), 32'(almost_full_n), 32'(TBL[k].xaf));
      chk($sformatf("R7 vec%0d half_full_n", k), 32'(half_full_n), 32'(TBL[k].xhf));
      chk($sformatf("R7 vec%0d empty_n", k), 32'(empty_n), 1);
    end

    // R2: default thresholds of 127
    do_reset(1'b1);
    wr_burst(127, 18'h0);
    settle();
    chk("R2 ae default at 127", 32'(almost_empty_n), 0);
    wr_burst(1, 18'h0);
    settle();
    chk("R2 ae default above 127", 32'(almost_empty_n), 1);
    wr_burst(DEPTH - 128 - 128, 18'h0);
    settle();
    chk("R2 af default free 128", 32'(almost_full_n), 1);
    wr_burst(1, 18'h0);
    settle();
    chk("R2 af default free 127", 32'(almost_full_n), 0);

    // R3 / R4 / R5: fill, overfill, drain in order
    do_reset(1'b1);
    wr_burst(DEPTH, 18'h15000);
    chk("R7 full_n after last write", 32'(full_n), 0);
    wr_burst(1, 18'h3FFFF);
    chk("R4 full_n stays low", 32'(full_n), 0);
    settle();
    mism = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd_word(d);
      if (d !== 18'h15000 + 18'(i)) mism++;
    end
    chk("R3 read order mismatches", 32'(mism), 0);
    chk("R7 empty_n after drain", 32'(empty_n), 0);
    settle();
    rd_word(d);
    chk("R4 no extra word stored / R5 dout held", 32'(d), 32'(18'h15000 + 18'(DEPTH - 1)));
    chk("R5 still empty", 32'(empty_n), 0);

    // R11: output enable only gates dout
    do_reset(1'b1);
    wr_burst(2, 18'h2ABCD);
    settle();
    oe_n = 1;
    rd_word(d);
    chk("R11 dout zero with oe_n high", 32'(d), 0);
    oe_n = 0;
    #1;
    chk("R11 read still happened", 32'(dout), 32'(18'h2ABCD));
    rd_word(d);
    chk("R3 second word", 32'(d), 32'(18'h2ABCE));

    // R6: load rotation wraps to almost-empty threshold
    do_reset(1'b1);
    load_reg(18'd2);
    load_reg(18'd5);
    load_reg(18'd0);
    load_reg(18'd20);
    wr_burst(10, 18'h0);
    settle();
    chk("R6 wrapped load set ae threshold 20", 32'(almost_empty_n), 0);

    // R8 / R9 / R10: enhanced mode
    do_reset(1'b0);
    chk("R10 delayed empty low after reset", 32'(empty_dly_n), 0);
    wr_en2 = 0;
    wr_burst(1, 18'h00111);
    settle();
    chk("R9 write blocked by wr_en2 low", 32'(empty_n), 0);
    wr_en2 = 1;
    wr_burst(1, 18'h00222);
    settle();
    chk("R9 write with wr_en2 high", 32'(empty_n), 1);
    chk("R10 delayed empty follows", 32'(empty_dly_n), 1);
    rd_en2 = 0;
    rd_word(d);
    chk("R9 read blocked by rd_en2 low", 32'(empty_n), 1);
    rd_en2 = 1;
    rd_word(d);
    chk("R9 read data with rd_en2 high", 32'(d), 32'(18'h00222));
    chk("R10 empty_n low", 32'(empty_n), 0);
    chk("R10 delayed empty one cycle behind", 32'(empty_dly_n), 1);
    @(negedge rd_clk);
    chk("R10 delayed empty catches up", 32'(empty_dly_n), 0);

    // R8 / R9 / R10: clearing feature bits after enhanced reset
    load_reg(18'd127);
    load_reg(18'd127);
    load_reg(18'd0);
    settle();
    wr_en2 = 0; rd_en2 = 0;
    wr_burst(1, 18'h00333);
    settle();
    chk("R9 wr_en2 ignored once bit cleared", 32'(empty_n), 1);
    rd_word(d);
    chk("R9 rd_en2 ignored once bit cleared", 32'(d), 32'(18'h00333));
    @(negedge rd_clk);
    chk("R10 delayed empty high when bit clear", 32'(empty_dly_n), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule